// File: doc/BRIEF.md
# Ticketed Configuration-Space Access Gateway

This block is a device-side register window placed in a vendor-specific capability of a PCI configuration space. Host software reaches the device's internal 32-bit address spaces indirectly through it. It picks an internal space, loads a data dword, and writes an address dword whose top bit is a direction/completion flag. The gateway then runs one single-dword read or write on an internal request/acknowledge memory port. It reports completion by flipping the flag: a write clears it and a read sets it.

Several host agents can share the window. Ownership is settled by a ticket scheme. An agent reads a self-advancing ticket counter, writes that ticket into the semaphore register while the semaphore is free, and reads the semaphore back. It owns the window only if the read-back value is its own ticket. Writes to the control, address and data registers from any agent that is not the owner are dropped. The gateway also checks the selected space and reports through a status field whether that space exists. An access to a space that does not exist finishes at once without touching the internal port.

Top module: `cfgwin_gateway`

## Requirements
- R1: After reset the semaphore reads 0, the first ticket read returns 1, the address, data and control registers read 0, and `mem_req` is low.
- R2: Each ticket read (offset base+0x8) returns the current ticket and advances it by one. Zero is skipped on wrap, so with a 3-bit ticket the sequence runs 1..7, 1.
- R3: A nonzero write to the semaphore (base+0xC) takes effect only while the semaphore reads 0, and it records the writing agent as owner. A nonzero write while the semaphore is held leaves it unchanged.
- R4: A zero write to the semaphore from the owner frees it. A zero write from any other agent is ignored.
- R5: Writes to control (base+0x4), address (base+0x10) or data (base+0x14) from an agent that does not own the semaphore are ignored.
- R6: Control bits 15:0 hold the space selector. Bits 31:29 read 3'b001 when the selector is 0x1, 0x2 or 0xA, and 3'b000 otherwise. All other control bits read 0 and ignore writes.
- R7: Writing the address with bit 31 = 1 in a supported space issues one internal write of the data register to address bits ADDR_W-1:0. Bit 31 reads 1 until the write is acknowledged and 0 afterwards.
- R8: Writing the address with bit 31 = 0 in a supported space issues one internal read. Once it is acknowledged, the data register holds the returned word and bit 31 reads 1.
- R9: An address write with bit 27 or bit 26 set is rejected: no internal request is made and the address register keeps its previous value.
- R10: An access in an unsupported space makes no internal request and completes at once. A read loads 0 into the data register and sets the flag. A write clears the flag.
- R11: While an internal access is outstanding, writes to control, address and data are ignored.
- R12: `mem_req` stays high, and `mem_we`, `mem_addr` and `mem_wdata` stay stable, until `mem_ack` is seen.
- R13: The dword at the capability base reads capability ID 0x09 in bits 7:0 and the next pointer in bits 15:8. All register offsets are dword offsets from the base (default 0xC0), and register reads return data one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration dword access this cycle |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_agent | input | AGENT_W | Identity of the requesting host agent |
| cfg_offset | input | 8 | Byte offset in configuration space (dword aligned) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid the cycle after a read |
| mem_req | output | 1 | Internal access request |
| mem_we | output | 1 | Internal access is a write |
| mem_space | output | 16 | Selected internal space |
| mem_addr | output | ADDR_W | Internal dword address |
| mem_wdata | output | 32 | Internal write data |
| mem_ack | input | 1 | Internal access done (one-cycle pulse) |
| mem_rdata | input | 32 | Internal read data, valid with `mem_ack` |

## Verification
The bench builds the gateway with TICKET_W = 3, so a dozen ticket reads are enough to reach the wrap from 7 back to 1 and confirm that zero is skipped. The other parameters stay at their defaults: base 0xC0, two-bit agent identity and a 26-bit internal address. With these values the illegal bits 27:26 lie just above the forwarded address field. The bench memory model can stretch its acknowledge latency, which keeps an access outstanding long enough to show that register writes made during it are dropped.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  localparam int DW      = 32;
  localparam int SPACE_W = 16;

  typedef enum logic [2:0] {
    RG_HDR  = 3'd0,
    RG_CTRL = 3'd1,
    RG_TICK = 3'd2,
    RG_SEM  = 3'd3,
    RG_ADDR = 3'd4,
    RG_DATA = 3'd5,
    RG_NONE = 3'd7
  } reg_idx_t;

  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_BUSY = 1'b1
  } eng_state_t;

  localparam logic [7:0] CAP_ID_VAL = 8'h09;

  function automatic logic space_ok(input logic [SPACE_W-1:0] sp);
    return (sp == 16'h0001) || (sp == 16'h0002) || (sp == 16'h000A);
  endfunction

endpackage

// File: rtl/cfgwin_rst_sync.sv
module cfgwin_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/cfgwin_sema.sv
module cfgwin_sema #(
  parameter int TICKET_W = 32,
  parameter int AGENT_W  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_rd,
  input  logic                sem_wr,
  input  logic [TICKET_W-1:0] sem_wval,
  input  logic [AGENT_W-1:0]  agent,
  output logic [TICKET_W-1:0] ticket,
  output logic [TICKET_W-1:0] sem_val,
  output logic                owner_ok
);
  localparam logic [TICKET_W-1:0] TICK_ONE = TICKET_W'(1);
  localparam logic [TICKET_W-1:0] TICK_MAX = {TICKET_W{1'b1}};

  logic [TICKET_W-1:0] tick_q, tick_n;
  logic [TICKET_W-1:0] sem_q, sem_n;
  logic [AGENT_W-1:0]  own_q, own_n;
  logic                held;
  logic                upd_en;

  assign held     = (sem_q != '0);
  assign owner_ok = held && (agent == own_q);

  always_comb begin
    tick_n = tick_q;
    sem_n  = sem_q;
    own_n  = own_q;
    if (tick_rd) begin
      tick_n = (tick_q == TICK_MAX) ? TICK_ONE : tick_q + TICK_ONE;
    end
    if (sem_wr) begin
      if (sem_wval == '0) begin
        if (owner_ok) sem_n = '0;
      end else if (!held) begin
        sem_n = sem_wval;
        own_n = agent;
      end
    end
  end

  assign upd_en = tick_rd | sem_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= TICK_ONE;
      sem_q  <= '0;
      own_q  <= '0;
    end else if (upd_en) begin
      tick_q <= tick_n;
      sem_q  <= sem_n;
      own_q  <= own_n;
    end
  end

  assign ticket  = tick_q;
  assign sem_val = sem_q;

  a_r2_ticket_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q != '0);
  a_r2_ticket_moves: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rd |=> (tick_q != $past(tick_q)));
  a_r3_no_steal: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_q != '0) |=> ((sem_q == $past(sem_q)) || (sem_q == '0)));
  a_r4_release_by_owner: assert property (@(posedge clk) disable iff (!rst_n)
    ((sem_q != '0) && !(sem_wr && owner_ok)) |=> (sem_q != '0));
endmodule

// File: rtl/cfgwin_engine.sv
module cfgwin_engine
  import cfgwin_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_ok,
  input  logic               ctrl_wr,
  input  logic               addr_wr,
  input  logic               data_wr,
  input  logic [DW-1:0]      wdata,
  output logic [SPACE_W-1:0] space_q,
  output logic [30:0]        addr_q,
  output logic               flag_q,
  output logic [DW-1:0]      data_q,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DW-1:0]      mem_wdata,
  input  logic               mem_ack,
  input  logic [DW-1:0]      mem_rdata
);
  eng_state_t         st_q, st_n;
  logic [SPACE_W-1:0] space_n;
  logic [30:0]        addr_n;
  logic               flag_n;
  logic [DW-1:0]      data_n;
  logic               we_q, we_n;
  logic               accept;
  logic               legal;
  logic               upd_en;

  assign accept = host_ok && (st_q == ENG_IDLE);
  assign legal  = (wdata[27:26] == 2'b00);

  always_comb begin
    st_n    = st_q;
    space_n = space_q;
    addr_n  = addr_q;
    flag_n  = flag_q;
    data_n  = data_q;
    we_n    = we_q;
    if (st_q == ENG_BUSY) begin
      if (mem_ack) begin
        st_n   = ENG_IDLE;
        flag_n = ~we_q;
        if (!we_q) data_n = mem_rdata;
      end
    end else if (accept) begin
      if (ctrl_wr) space_n = wdata[SPACE_W-1:0];
      if (data_wr) data_n = wdata;
      if (addr_wr && legal) begin
        addr_n = wdata[30:0];
        we_n   = wdata[31];
        if (space_ok(space_q)) begin
          st_n   = ENG_BUSY;
          flag_n = wdata[31];
        end else begin
          flag_n = ~wdata[31];
          if (!wdata[31]) data_n = '0;
        end
      end
    end
  end

  assign upd_en = accept | ((st_q == ENG_BUSY) & mem_ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ENG_IDLE;
      space_q <= '0;
      addr_q  <= '0;
      flag_q  <= 1'b0;
      data_q  <= '0;
      we_q    <= 1'b0;
    end else if (upd_en) begin
      st_q    <= st_n;
      space_q <= space_n;
      addr_q  <= addr_n;
      flag_q  <= flag_n;
      data_q  <= data_n;
      we_q    <= we_n;
    end
  end

  assign mem_req   = (st_q == ENG_BUSY);
  assign mem_we    = we_q;
  assign mem_addr  = addr_q[ADDR_W-1:0];
  assign mem_wdata = data_q;

  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)));
  a_r10_space_ok: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> space_ok(space_q));
  a_r7_write_done: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (!flag_q && !mem_req));
  a_r8_read_done: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> (flag_q && (data_q == $past(mem_rdata))));
  a_r11_space_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> $stable(space_q));
endmodule

// File: rtl/cfgwin_gateway.sv
module cfgwin_gateway
  import cfgwin_pkg::*;
#(
  parameter logic [7:0] CAP_BASE = 8'hC0,
  parameter logic [7:0] NEXT_PTR = 8'h00,
  parameter int         TICKET_W = 32,
  parameter int         AGENT_W  = 2,
  parameter int         ADDR_W   = 26
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_valid,
  input  logic               cfg_write,
  input  logic [AGENT_W-1:0] cfg_agent,
  input  logic [7:0]         cfg_offset,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [15:0]        mem_space,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [31:0]        mem_wdata,
  input  logic               mem_ack,
  input  logic [31:0]        mem_rdata
);
  localparam logic [5:0] BASE_DW = CAP_BASE[7:2];
  localparam int         NREGS   = 6;

  logic               rst_s;
  logic [5:0]         rel;
  reg_idx_t           idx;
  logic               rd_en, wr_en;
  logic [TICKET_W-1:0] ticket, sem_val;
  logic               owner_ok;
  logic [SPACE_W-1:0] space_q;
  logic [30:0]        addr_q;
  logic               flag_q;
  logic [DW-1:0]      data_q;
  logic [DW-1:0]      rd_n, rdata_q;

  cfgwin_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s)
  );

  assign rel = cfg_offset[7:2] - BASE_DW;

  always_comb begin
    idx = RG_NONE;
    if ((cfg_offset[1:0] == 2'b00) && (rel < 6'(NREGS))) idx = reg_idx_t'(rel[2:0]);
  end

  assign rd_en = cfg_valid && !cfg_write;
  assign wr_en = cfg_valid && cfg_write;

  cfgwin_sema #(.TICKET_W(TICKET_W), .AGENT_W(AGENT_W)) u_sema (
    .clk      (clk),
    .rst_n    (rst_s),
    .tick_rd  (rd_en && (idx == RG_TICK)),
    .sem_wr   (wr_en && (idx == RG_SEM)),
    .sem_wval (cfg_wdata[TICKET_W-1:0]),
    .agent    (cfg_agent),
    .ticket   (ticket),
    .sem_val  (sem_val),
    .owner_ok (owner_ok)
  );

  cfgwin_engine #(.ADDR_W(ADDR_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_s),
    .host_ok   (owner_ok),
    .ctrl_wr   (wr_en && (idx == RG_CTRL)),
    .addr_wr   (wr_en && (idx == RG_ADDR)),
    .data_wr   (wr_en && (idx == RG_DATA)),
    .wdata     (cfg_wdata),
    .space_q   (space_q),
    .addr_q    (addr_q),
    .flag_q    (flag_q),
    .data_q    (data_q),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata)
  );

  assign mem_space = space_q;

  always_comb begin
    rd_n = '0;
    unique case (idx)
      RG_HDR:  rd_n = {16'h0000, NEXT_PTR, CAP_ID_VAL};
      RG_CTRL: rd_n = {(space_ok(space_q) ? 3'b001 : 3'b000), 13'h0000, space_q};
      RG_TICK: rd_n = 32'(ticket);
      RG_SEM:  rd_n = 32'(sem_val);
      RG_ADDR: rd_n = {flag_q, addr_q};
      RG_DATA: rd_n = data_q;
      default: rd_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_n;
  end

  assign cfg_rdata = rdata_q;

  a_r5_outsider_no_launch: assert property (@(posedge clk) disable iff (!rst_s)
    (!mem_req && !owner_ok) |=> !mem_req);
  a_r9_illegal_no_launch: assert property (@(posedge clk) disable iff (!rst_s)
    (!mem_req && wr_en && (idx == RG_ADDR) && (cfg_wdata[27:26] != 2'b00)) |=> !mem_req);
endmodule

// File: tb/cfgwin_gateway_test.sv
module cfgwin_gateway_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] O_HDR = 8'hC0, O_CTRL = 8'hC4, O_TICK = 8'hC8,
                         O_SEM = 8'hCC, O_ADDR = 8'hD0, O_DATA = 8'hD4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_valid, cfg_write;
  logic [1:0]  cfg_agent;
  logic [7:0]  cfg_offset;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [15:0] mem_space;
  logic [25:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  int n_chk = 0, n_fail = 0;
  int lat = 0, cnt = 0, n_req = 0, n_unstable = 0;
  logic [25:0] cap_addr;
  logic [31:0] cap_wdata;
  logic [31:0] mem [0:31];
  logic        finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgwin_gateway #(.TICKET_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
    .cfg_agent(cfg_agent), .cfg_offset(cfg_offset), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_space(mem_space),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [4:0] midx(input logic [15:0] sp, input logic [25:0] a);
    return {sp[0], a[3:0]};
  endfunction

  assign mem_rdata = mem[midx(mem_space, mem_addr)];

  // internal memory model with adjustable acknowledge latency
  always @(posedge clk) begin
    if (!mem_req) begin
      cnt <= 0; mem_ack <= 1'b0;
    end else if (mem_ack) begin
      cnt <= 0; mem_ack <= 1'b0;
    end else begin
      if (cnt == 0) begin
        cap_addr <= mem_addr; cap_wdata <= mem_wdata; n_req <= n_req + 1;
      end else if (mem_addr != cap_addr || mem_wdata != cap_wdata) begin
        n_unstable <= n_unstable + 1;
      end
      if (cnt >= lat) begin
        mem_ack <= 1'b1;
        if (mem_we) mem[midx(mem_space, mem_addr)] <= mem_wdata;
      end else cnt <= cnt + 1;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] ag, input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_write = 1'b1; cfg_agent = ag; cfg_offset = off; cfg_wdata = d;
    @(negedge clk);
    cfg_valid = 1'b0; cfg_write = 1'b0;
  endtask

  task automatic cfg_rd(input logic [1:0] ag, input logic [7:0] off, output logic [31:0] d);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_write = 1'b0; cfg_agent = ag; cfg_offset = off;
    @(negedge clk);
    cfg_valid = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic wait_flag(input logic exp, input string req);
    logic [31:0] v;
    int tries = 0;
    do begin
      cfg_rd(2'd0, O_ADDR, v);
      tries++;
    end while (v[31] != exp && tries < 50);
    chk(v[31] == exp, req, {31'h0, v[31]}, {31'h0, exp});
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk(mem_req == 1'b0, "R1 mem_req", {31'h0, mem_req}, 32'h0);
    cfg_rd(0, O_SEM, v);  chk(v == 32'h0, "R1 sem", v, 32'h0);
    cfg_rd(0, O_ADDR, v); chk(v == 32'h0, "R1 addr", v, 32'h0);
    cfg_rd(0, O_DATA, v); chk(v == 32'h0, "R1 data", v, 32'h0);
    cfg_rd(0, O_CTRL, v); chk(v == 32'h0, "R1 ctrl", v, 32'h0);
    cfg_rd(0, O_TICK, v); chk(v == 32'h1, "R1 first ticket", v, 32'h1);
    cfg_rd(0, O_TICK, v); chk(v == 32'h2, "R2 ticket advance", v, 32'h2);
  endtask

  task automatic t_header;
    logic [31:0] v;
    cfg_rd(0, O_HDR, v); chk(v == 32'h0000_0009, "R13 header", v, 32'h9);
  endtask

  task automatic t_acquire;
    logic [31:0] v, t0, t1;
    cfg_rd(0, O_SEM, v);  chk(v == 0, "R3 free", v, 0);
    cfg_rd(0, O_TICK, t0);
    cfg_wr(0, O_SEM, t0);
    cfg_rd(0, O_SEM, v);  chk(v == t0, "R3 winner", v, t0);
    cfg_rd(1, O_TICK, t1);
    cfg_wr(1, O_SEM, t1);
    cfg_rd(1, O_SEM, v);  chk(v == t0, "R3 loser ignored", v, t0);
  endtask

  task automatic t_nonowner;
    logic [31:0] v;
    cfg_wr(1, O_CTRL, 32'h2);
    cfg_wr(1, O_DATA, 32'h55);
    cfg_wr(1, O_ADDR, 32'h8000_0001);
    cfg_rd(1, O_CTRL, v); chk(v == 0, "R5 ctrl", v, 0);
    cfg_rd(1, O_DATA, v); chk(v == 0, "R5 data", v, 0);
    cfg_rd(1, O_ADDR, v); chk(v == 0, "R5 addr", v, 0);
    chk(n_req == 0, "R5 no request", n_req, 0);
    cfg_wr(1, O_SEM, 32'h0);
    cfg_rd(1, O_SEM, v);  chk(v == 32'h3, "R4 outsider release ignored", v, 32'h3);
  endtask

  task automatic t_space;
    logic [31:0] v;
    cfg_wr(0, O_CTRL, 32'h1); cfg_rd(0, O_CTRL, v); chk(v == 32'h2000_0001, "R6 space1", v, 32'h2000_0001);
    cfg_wr(0, O_CTRL, 32'hA); cfg_rd(0, O_CTRL, v); chk(v == 32'h2000_000A, "R6 spaceA", v, 32'h2000_000A);
    cfg_wr(0, O_CTRL, 32'h3); cfg_rd(0, O_CTRL, v); chk(v == 32'h0000_0003, "R6 space3", v, 32'h3);
    cfg_wr(0, O_CTRL, 32'hE00F_0002); cfg_rd(0, O_CTRL, v); chk(v == 32'h2000_0002, "R6 space2 ro bits", v, 32'h2000_0002);
  endtask

  task automatic t_write;
    logic [31:0] v;
    cfg_wr(0, O_DATA, 32'hDEAD_BEEF);
    cfg_wr(0, O_ADDR, 32'h8000_0005);
    wait_flag(1'b0, "R7 flag clears");
    chk(mem[5] == 32'hDEAD_BEEF, "R7 memory written", mem[5], 32'hDEAD_BEEF);
    cfg_rd(0, O_ADDR, v); chk(v == 32'h0000_0005, "R7 addr readback", v, 32'h5);
    chk(n_req == 1, "R7 one request", n_req, 1);
  endtask

  task automatic t_read;
    logic [31:0] v;
    cfg_wr(0, O_ADDR, 32'h0000_0005);
    wait_flag(1'b1, "R8 flag sets");
    cfg_rd(0, O_DATA, v); chk(v == 32'hDEAD_BEEF, "R8 read data", v, 32'hDEAD_BEEF);
    cfg_wr(0, O_CTRL, 32'h1);
    cfg_wr(0, O_ADDR, 32'h0000_0003);
    wait_flag(1'b1, "R8 flag sets space1");
    cfg_rd(0, O_DATA, v); chk(v == 32'hA000_0013, "R8 read space1", v, 32'hA000_0013);
  endtask

  task automatic t_illegal;
    logic [31:0] v;
    int r0 = n_req;
    cfg_wr(0, O_ADDR, 32'h0400_0001);
    cfg_wr(0, O_ADDR, 32'h8800_0001);
    repeat (4) @(negedge clk);
    cfg_rd(0, O_ADDR, v); chk(v == 32'h8000_0003, "R9 addr kept", v, 32'h8000_0003);
    chk(n_req == r0, "R9 no request", n_req, r0);
  endtask

  task automatic t_busy;
    logic [31:0] v;
    int r0;
    cfg_wr(0, O_CTRL, 32'h2);
    r0 = n_req;
    lat = 8;
    cfg_wr(0, O_ADDR, 32'h0000_0002);
    cfg_wr(0, O_CTRL, 32'h1);
    cfg_wr(0, O_DATA, 32'h1234);
    cfg_wr(0, O_ADDR, 32'h8000_0009);
    wait_flag(1'b1, "R11 read completes");
    lat = 0;
    cfg_rd(0, O_CTRL, v); chk(v == 32'h2000_0002, "R11 ctrl kept", v, 32'h2000_0002);
    cfg_rd(0, O_DATA, v); chk(v == 32'hA000_0002, "R11 data from memory", v, 32'hA000_0002);
    cfg_rd(0, O_ADDR, v); chk(v == 32'h8000_0002, "R11 addr kept", v, 32'h8000_0002);
    chk(n_req == r0 + 1, "R11 single request", n_req, r0 + 1);
    chk(n_unstable == 0, "R12 request stable", n_unstable, 0);
  endtask

  task automatic t_unsup;
    logic [31:0] v;
    int r0 = n_req;
    cfg_wr(0, O_CTRL, 32'h3);
    cfg_wr(0, O_ADDR, 32'h0000_000B);
    cfg_rd(0, O_ADDR, v); chk(v == 32'h8000_000B, "R10 read done at once", v, 32'h8000_000B);
    cfg_rd(0, O_DATA, v); chk(v == 32'h0, "R10 read zero", v, 0);
    cfg_wr(0, O_ADDR, 32'h8000_000C);
    cfg_rd(0, O_ADDR, v); chk(v == 32'h0000_000C, "R10 write done at once", v, 32'hC);
    chk(n_req == r0, "R10 no request", n_req, r0);
  endtask

  task automatic t_release;
    logic [31:0] v, t;
    cfg_wr(0, O_SEM, 32'h0);
    cfg_rd(0, O_SEM, v); chk(v == 0, "R4 owner release", v, 0);
    cfg_rd(1, O_TICK, t);
    cfg_wr(1, O_SEM, t);
    cfg_rd(1, O_SEM, v); chk(v == t, "R3 new owner", v, t);
    cfg_wr(1, O_CTRL, 32'h2);
    cfg_rd(1, O_CTRL, v); chk(v == 32'h2000_0002, "R5 new owner writes", v, 32'h2000_0002);
    cfg_wr(0, O_CTRL, 32'h1);
    cfg_rd(0, O_CTRL, v); chk(v == 32'h2000_0002, "R5 old owner shut out", v, 32'h2000_0002);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    int k = 0;
    do begin cfg_rd(0, O_TICK, v); k++; end while (v != 32'h7 && k < 10);
    chk(v == 32'h7, "R2 reach max", v, 32'h7);
    cfg_rd(0, O_TICK, v); chk(v == 32'h1, "R2 wrap skips zero", v, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 32'hA000_0000 + 32'(i);
    cfg_valid = 0; cfg_write = 0; cfg_agent = 0; cfg_offset = 0; cfg_wdata = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_header;
    t_acquire;
    t_nonowner;
    t_space;
    t_write;
    t_read;
    t_illegal;
    t_busy;
    t_unsup;
    t_release;
    t_wrap;
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule